// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block owns the control side of a system clock switch. Four sources can drive the core clock: the 26 MHz reference, a 32 kHz slow clock, and two high-speed oscillators. Software issues a source-select write or an enable or disable request for either high-speed oscillator. The block then drives the clock mux select, the divide-by-two select, and the oscillator enable, disable and gate lines as a timed sequence of single steps. The core never runs from the faster oscillator without the halving divider, and no oscillator gate opens before its oscillator has settled.

Settle gaps are counted in reference-clock cycles. The parameter `CYC_PER_US` (26 by default) sets the cycles per microsecond. `ON_US` and `OFF_US` set the enable and disable gaps, 150 µs and 50 µs by default. The block accepts one operation at a time. `busy` is high while an operation runs, and `done` pulses for one cycle when it completes. The analog mux and the oscillators are outside this block.

Top module: `clk_src_seq`

## Requirements
- R1: After reset: `mux_sel`=0 (reference), `div2_sel`=0, `osc1_en`=0, `osc1_gate`=0, `osc2_dis`=1, `osc2_gate`=0, `busy`=0, `done`=0.
- R2: Source codes are 0 for the reference, 1 for the slow clock, 2 for oscillator 2 and 3 for oscillator 1. A write of code 3 sets `div2_sel` on the first edge after acceptance. `mux_sel` becomes 3 on the following edge.
- R3: A write of code 0, 1 or 2 loads `mux_sel` on the first edge after acceptance. `div2_sel` clears on the following edge.
- R4: An oscillator 1 enable request sets `osc1_en` on the first edge after acceptance (E0). `osc1_gate` opens at edge E0+ON_US·CYC_PER_US, and the operation completes on that same edge.
- R5: An oscillator 2 enable request clears `osc2_dis` at E0. `osc2_gate` opens at E0+ON_US·CYC_PER_US. The operation completes OFF_US·CYC_PER_US edges after the gate opens.
- R6: A disable request closes that oscillator's gate at E0. At E0+OFF_US·CYC_PER_US it clears `osc1_en` or sets `osc2_dis`. It completes at E0+2·OFF_US·CYC_PER_US.
- R7: `busy` is high from E0 until the completing edge. On the completing edge `done` rises for exactly one cycle, and `busy` falls on that same edge.
- R8: Any request presented while `busy` is high is ignored and changes no output.
- R9: If several requests are presented together while idle, only the one with the highest priority is taken. The order, highest first, is: source write, oscillator 1 enable, oscillator 1 disable, oscillator 2 enable, oscillator 2 disable.
- R10: `div2_sel` and `mux_sel` never change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Source-select write strobe |
| sel_val | input | 2 | Requested source code |
| osc1_on_req | input | 1 | Oscillator 1 enable request |
| osc1_off_req | input | 1 | Oscillator 1 disable request |
| osc2_on_req | input | 1 | Oscillator 2 enable request |
| osc2_off_req | input | 1 | Oscillator 2 disable request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mux_sel | output | 2 | Clock mux select |
| div2_sel | output | 1 | Divide-by-two select |
| osc1_en | output | 1 | Oscillator 1 high-speed enable |
| osc1_gate | output | 1 | Oscillator 1 clock gate open |
| osc2_dis | output | 1 | Oscillator 2 disable switch |
| osc2_gate | output | 1 | Oscillator 2 core clock gate open |

## Verification
The assertions check on every cycle the properties that hold on a single edge or between two edges. The divider and the mux never change together. The mux only reaches code 3 with the divider already set, and the divider only drops after the mux has left code 3. No gate is open while its oscillator is off. `done` is a single-cycle pulse that never overlaps `busy`. A counter in the checker also confirms that oscillator 1 has been enabled for at least the full settle gap when its gate opens.

Only the bench scenarios can show the exact cycle of every step, the oscillator 2 settle tail, the spacing of the disable sequence, and that requests made while busy are dropped. The same holds for the priority among simultaneous requests. The bench predicts each output change with its cycle number and matches it against the observed changes.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

    localparam logic [1:0] SRC_REF  = 2'd0;
    localparam logic [1:0] SRC_SLOW = 2'd1;
    localparam logic [1:0] SRC_OSC2 = 2'd2;
    localparam logic [1:0] SRC_OSC1 = 2'd3;

    typedef enum logic [2:0] {
        REQ_NONE,
        REQ_SEL,
        REQ_O1_ON,
        REQ_O1_OFF,
        REQ_O2_ON,
        REQ_O2_OFF
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SW_MUX,
        ST_SW_DIV,
        ST_ON_WAIT,
        ST_ON_SETTLE,
        ST_OFF_GAP1,
        ST_OFF_GAP2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic [1:0] mux;
        logic       div2;
        logic       o1_en;
        logic       o1_gate;
        logic       o2_dis;
        logic       o2_gate;
        logic       done;
        logic       osc_sel;
        logic [1:0] tgt;
    } seq_regs_t;

endpackage

// File: rtl/clk_seq_arb.sv
module clk_seq_arb
    import clk_seq_pkg::*;
(
    input  logic      idle,
    input  logic      sel_wr,
    input  logic      o1_on,
    input  logic      o1_off,
    input  logic      o2_on,
    input  logic      o2_off,
    output req_kind_e kind
);
    always_comb begin
        kind = REQ_NONE;
        if (idle) begin
            if (sel_wr)       kind = REQ_SEL;
            else if (o1_on)   kind = REQ_O1_ON;
            else if (o1_off)  kind = REQ_O1_OFF;
            else if (o2_on)   kind = REQ_O2_ON;
            else if (o2_off)  kind = REQ_O2_OFF;
        end
    end
endmodule

// File: rtl/clk_seq_timer.sv
module clk_seq_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/clk_src_seq.sv
module clk_src_seq
    import clk_seq_pkg::*;
#(
    parameter int CYC_PER_US = 26,
    parameter int ON_US      = 150,
    parameter int OFF_US     = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [1:0] sel_val,
    input  logic       osc1_on_req,
    input  logic       osc1_off_req,
    input  logic       osc2_on_req,
    input  logic       osc2_off_req,
    output logic       busy,
    output logic       done,
    output logic [1:0] mux_sel,
    output logic       div2_sel,
    output logic       osc1_en,
    output logic       osc1_gate,
    output logic       osc2_dis,
    output logic       osc2_gate
);
    localparam int ON_CYC  = ON_US * CYC_PER_US;
    localparam int OFF_CYC = OFF_US * CYC_PER_US;
    localparam int MAX_CYC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC) + 1;
    localparam logic [CNT_W-1:0] ON_LOAD  = CNT_W'(ON_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LOAD = CNT_W'(OFF_CYC - 1);

    seq_regs_t        r_d, r_q;
    req_kind_e        req_kind;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    clk_seq_arb u_arb (
        .idle   (r_q.st == ST_IDLE),
        .sel_wr (sel_wr),
        .o1_on  (osc1_on_req),
        .o1_off (osc1_off_req),
        .o2_on  (osc2_on_req),
        .o2_off (osc2_off_req),
        .kind   (req_kind)
    );

    clk_seq_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = ON_LOAD;
        unique case (r_q.st)
            ST_IDLE: begin
                unique case (req_kind)
                    REQ_SEL: begin
                        r_d.tgt = sel_val;
                        if (sel_val == SRC_OSC1) begin
                            r_d.div2 = 1'b1;        // halve first
                            r_d.st   = ST_SW_MUX;
                        end else begin
                            r_d.mux  = sel_val;     // move mux first
                            r_d.st   = ST_SW_DIV;
                        end
                    end
                    REQ_O1_ON: begin
                        r_d.o1_en   = 1'b1;
                        r_d.osc_sel = 1'b0;
                        tmr_load    = 1'b1;
                        r_d.st      = ST_ON_WAIT;
                    end
                    REQ_O2_ON: begin
                        r_d.o2_dis  = 1'b0;
                        r_d.osc_sel = 1'b1;
                        tmr_load    = 1'b1;
                        r_d.st      = ST_ON_WAIT;
                    end
                    REQ_O1_OFF: begin
                        r_d.o1_gate = 1'b0;
                        r_d.osc_sel = 1'b0;
                        tmr_load    = 1'b1;
                        tmr_val     = OFF_LOAD;
                        r_d.st      = ST_OFF_GAP1;
                    end
                    REQ_O2_OFF: begin
                        r_d.o2_gate = 1'b0;
                        r_d.osc_sel = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = OFF_LOAD;
                        r_d.st      = ST_OFF_GAP1;
                    end
                    default: ;
                endcase
            end
            ST_SW_MUX: begin
                r_d.mux  = r_q.tgt;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            ST_SW_DIV: begin
                r_d.div2 = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            ST_ON_WAIT: begin
                if (tmr_zero) begin
                    if (!r_q.osc_sel) begin
                        r_d.o1_gate = 1'b1;
                        r_d.done    = 1'b1;
                        r_d.st      = ST_IDLE;
                    end else begin
                        r_d.o2_gate = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = OFF_LOAD;
                        r_d.st      = ST_ON_SETTLE;
                    end
                end
            end
            ST_ON_SETTLE: begin
                if (tmr_zero) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_OFF_GAP1: begin
                if (tmr_zero) begin
                    if (!r_q.osc_sel) r_d.o1_en  = 1'b0;
                    else              r_d.o2_dis = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = OFF_LOAD;
                    r_d.st   = ST_OFF_GAP2;
                end
            end
            ST_OFF_GAP2: begin
                if (tmr_zero) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.mux     <= SRC_REF;
            r_q.o2_dis  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign mux_sel   = r_q.mux;
    assign div2_sel  = r_q.div2;
    assign osc1_en   = r_q.o1_en;
    assign osc1_gate = r_q.o1_gate;
    assign osc2_dis  = r_q.o2_dis;
    assign osc2_gate = r_q.o2_gate;
endmodule

// File: rtl/clk_src_seq_chk.sv
module clk_src_seq_chk #(
    parameter int ON_CYC = 3900
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] mux_sel,
    input logic       div2_sel,
    input logic       osc1_en,
    input logic       osc1_gate,
    input logic       osc2_dis,
    input logic       osc2_gate
);
    int unsigned en1_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   en1_age <= 0;
        else if (!osc1_en)            en1_age <= 0;
        else if (en1_age < ON_CYC + 1) en1_age <= en1_age + 1;
    end

    a_r10_div_mux_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(div2_sel) && !$stable(mux_sel)));

    a_r2_halve_before_osc1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mux_sel) && mux_sel == 2'd3) |-> (div2_sel && $past(div2_sel)));

    a_r3_full_after_mux: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div2_sel) |-> ($stable(mux_sel) && mux_sel != 2'd3));

    a_r4_gate1_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        osc1_gate |-> osc1_en);

    a_r4_gate1_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc1_gate) |-> (en1_age >= ON_CYC));

    a_r5_gate2_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
        osc2_gate |-> !osc2_dis);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind clk_src_seq clk_src_seq_chk #(.ON_CYC(ON_US * CYC_PER_US)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mux_sel   (mux_sel),
    .div2_sel  (div2_sel),
    .osc1_en   (osc1_en),
    .osc1_gate (osc1_gate),
    .osc2_dis  (osc2_dis),
    .osc2_gate (osc2_gate)
);

// File: tb/clk_src_seq_tb_top.sv
module clk_src_seq_tb_top;
    localparam int NON  = 150 * 26;
    localparam int NOFF = 50 * 26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_val = 2'd0;
    logic       osc1_on_req = 1'b0, osc1_off_req = 1'b0;
    logic       osc2_on_req = 1'b0, osc2_off_req = 1'b0;
    logic       busy, done, div2_sel, osc1_en, osc1_gate, osc2_dis, osc2_gate;
    logic [1:0] mux_sel;

    always #10 clk = ~clk;

    clk_src_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_val(sel_val),
        .osc1_on_req(osc1_on_req), .osc1_off_req(osc1_off_req),
        .osc2_on_req(osc2_on_req), .osc2_off_req(osc2_off_req),
        .busy(busy), .done(done), .mux_sel(mux_sel), .div2_sel(div2_sel),
        .osc1_en(osc1_en), .osc1_gate(osc1_gate), .osc2_dis(osc2_dis),
        .osc2_gate(osc2_gate)
    );

    typedef struct {
        int         cyc;
        logic [8:0] vec;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0, n_bad = 0;
    bit   mon_on = 0;
    logic [8:0] prev_vec;

    // model state: {busy, done, mux[1:0], div2, o1en, o1gate, o2dis, o2gate}
    logic       m_busy = 0, m_done = 0, m_div = 0, m_e1 = 0, m_g1 = 0, m_d2 = 1, m_g2 = 0;
    logic [1:0] m_mux = 0;
    int         c0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [8:0] dut_vec();
        return {busy, done, mux_sel, div2_sel, osc1_en, osc1_gate, osc2_dis, osc2_gate};
    endfunction

    function automatic logic [8:0] mdl_vec();
        return {m_busy, m_done, m_mux, m_div, m_e1, m_g1, m_d2, m_g2};
    endfunction

    function automatic void push(int k, string tag);
        exp_t e;
        e.cyc = c0 + k;
        e.vec = mdl_vec();
        e.tag = tag;
        exp_q.push_back(e);
    endfunction

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: each observed output change is matched with the next prediction
    always @(negedge clk) begin
        if (mon_on) begin
            logic [8:0] cur;
            cur = dut_vec();
            if (cur !== prev_vec) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8 unexpected change at cycle %0d: actual=%b expected=%b",
                             cyc, cur, prev_vec);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.cyc != cyc || e.vec !== cur) begin
                        n_bad++;
                        $display("FAIL %s: actual cyc=%0d vec=%b expected cyc=%0d vec=%b",
                                 e.tag, cyc, cur, e.cyc, e.vec);
                    end
                end
            end
            prev_vec = cur;
        end
    end

    // Driver tasks: drive the request at a negedge, predict every change
    task automatic do_sel(logic [1:0] t, bit with_off1, string tag);
        @(negedge clk);
        c0 = cyc + 1;
        sel_val = t; sel_wr = 1'b1; osc1_off_req = with_off1;
        if (t == 2'd3) begin
            m_div = 1; m_busy = 1; push(0, tag);
            m_mux = t; m_busy = 0; m_done = 1; push(1, tag);   // R10: separate edges
        end else begin
            m_mux = t; m_busy = 1; push(0, tag);
            m_div = 0; m_busy = 0; m_done = 1; push(1, tag);   // R10: separate edges
        end
        m_done = 0; push(2, "R7");
        @(negedge clk);
        sel_wr = 1'b0; osc1_off_req = 1'b0;
        wait_cyc(c0 + 4);
    endtask

    task automatic do_osc1_on();
        @(negedge clk);
        c0 = cyc + 1;
        osc1_on_req = 1'b1;
        m_e1 = 1; m_busy = 1; push(0, "R4");
        m_g1 = 1; m_busy = 0; m_done = 1; push(NON, "R4");
        m_done = 0; push(NON + 1, "R7");
        @(negedge clk);
        osc1_on_req = 1'b0;
        // R8: requests while busy must be ignored
        wait_cyc(c0 + 10);
        sel_wr = 1'b1; sel_val = 2'd1; osc2_on_req = 1'b1; osc1_off_req = 1'b1;
        @(negedge clk);
        sel_wr = 1'b0; osc2_on_req = 1'b0; osc1_off_req = 1'b0;
        wait_cyc(c0 + NON - 1);
        sel_wr = 1'b1; sel_val = 2'd0;
        @(negedge clk);
        sel_wr = 1'b0;
        wait_cyc(c0 + NON + 3);
    endtask

    task automatic do_osc2_on();
        @(negedge clk);
        c0 = cyc + 1;
        osc2_on_req = 1'b1;
        m_d2 = 0; m_busy = 1; push(0, "R5");
        m_g2 = 1; push(NON, "R5");
        m_busy = 0; m_done = 1; push(NON + NOFF, "R5");
        m_done = 0; push(NON + NOFF + 1, "R7");
        @(negedge clk);
        osc2_on_req = 1'b0;
        wait_cyc(c0 + NON + 5);
        osc1_off_req = 1'b1;                      // R8: ignored during settle tail
        @(negedge clk);
        osc1_off_req = 1'b0;
        wait_cyc(c0 + NON + NOFF + 3);
    endtask

    task automatic do_off(bit which2);
        @(negedge clk);
        c0 = cyc + 1;
        if (which2) osc2_off_req = 1'b1; else osc1_off_req = 1'b1;
        if (which2) m_g2 = 0; else m_g1 = 0;
        m_busy = 1; push(0, "R6");
        if (which2) m_d2 = 1; else m_e1 = 0;
        push(NOFF, "R6");
        m_busy = 0; m_done = 1; push(2 * NOFF, "R6");
        m_done = 0; push(2 * NOFF + 1, "R7");
        @(negedge clk);
        osc1_off_req = 1'b0; osc2_off_req = 1'b0;
        wait_cyc(c0 + 2 * NOFF + 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (dut_vec() !== 9'b0_0_00_0_0_0_1_0) begin
            n_bad++;
            $display("FAIL R1 reset state: actual=%b expected=%b", dut_vec(), 9'b000000010);
        end
        prev_vec = dut_vec();
        mon_on = 1;

        do_sel(2'd3, 0, "R2");          // reference -> osc1: halve then mux
        do_sel(2'd0, 0, "R3");          // osc1 -> reference: mux then full rate
        do_osc1_on();                   // R4 plus ignored requests (R8)
        do_osc2_on();                   // R5
        do_sel(2'd2, 0, "R3");
        do_sel(2'd3, 0, "R2");
        do_sel(2'd1, 0, "R3");
        do_sel(2'd2, 1, "R9");          // source write wins over osc1 disable
        do_off(1'b0);                   // R6 osc1
        do_off(1'b1);                   // R6 osc2
        do_sel(2'd0, 0, "R3");
        osc1_on_req = 1'b1; osc2_off_req = 1'b1;   // R9: osc1 enable beats osc2 disable
        @(negedge clk);
        c0 = cyc;
        osc1_on_req = 1'b0; osc2_off_req = 1'b0;
        m_e1 = 1; m_busy = 1; push(0, "R9");
        m_g1 = 1; m_busy = 0; m_done = 1; push(NON, "R9");
        m_done = 0; push(NON + 1, "R7");
        wait_cyc(c0 + NON + 4);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 missing changes: actual=%0d pending expected=0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL R7 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule